// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit linear address into a physical address once the translation cache has missed. It fetches one entry from a page directory and then one entry from a page table. Both fetches go through a single 32-bit memory port that can read and write. Each entry is checked for presence and for user/supervisor and read/write permission. When a walk succeeds, the walker returns the 20-bit frame number, a physical address and a fill request for the translation cache. When a walk fails, it reports a page fault and keeps the faulting linear address in a register.

A request is accepted only while `idle` is high. A walk finishes with a one-cycle `walk_done` pulse, and `walk_fault` tells whether it ended in a fault. The accessed and dirty flags are updated by read-modify-write through the same port. An entry is written back only when a flag actually changes, and that write completes before the walk moves on. Entry layout: bit 0 present, bit 1 writable, bit 2 user-accessible, bit 5 accessed, bit 6 dirty, bits 31:12 frame number.

Top module: `pt_walker`

## Requirements
- R1: After reset, `idle` is 1, `mem_req` is 0, `walk_done` is 0 and `fault_addr` is 0.
- R2: The directory entry is read at {dir_base[31:12], lin[31:22], 2'b00}; the low 12 bits of `dir_base` have no effect on the walk.
- R3: The table entry is read at {directory entry[31:12], lin[21:12], 2'b00}.
- R4: An entry with bit 0 clear at either level ends the walk with `walk_fault`=1 and `fill_valid`=0. A faulting entry is never written back.
- R5: A user access faults if bit 2 is clear in either entry. A user write faults if bit 1 is clear in either entry. Supervisor accesses are never refused on these bits.
- R6: Every entry that passes its checks ends with bit 5 set. The table entry also gets bit 6 set when the access is a write. Bit 6 of a directory entry is never set by the walker.
- R7: An entry is written back only when the update changes it, so a walk over entries that already carry the needed flags issues no writes.
- R8: On success, `walk_done` pulses for one cycle with `fill_valid`=1. At the same time, `fill_vpn`=lin[31:12], `fill_pfn`=table entry[31:12] and `phys_addr`={fill_pfn, lin[11:0]}.
- R9: `fault_addr` takes the linear address of each faulting walk and holds its value through successful walks.
- R10: `mem_req` stays high with a stable address, write-enable and write data until `mem_ack`. Only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken while idle) |
| req_lin | input | 32 | Linear address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| dir_base | input | 32 | Physical base of the page directory |
| idle | output | 1 | Walker can accept a request |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |
| walk_done | output | 1 | One-cycle end-of-walk pulse |
| walk_fault | output | 1 | Walk ended in a page fault (with walk_done) |
| phys_addr | output | 32 | Translated physical address |
| fill_valid | output | 1 | Translation cache fill request |
| fill_vpn | output | 20 | Virtual page number of the fill |
| fill_pfn | output | 20 | Frame number of the fill |
| fault_addr | output | 32 | Linear address of the last fault |

## Verification
The assertions assume that `mem_ack` arrives only while `mem_req` is high and lasts exactly one cycle. They also assume that `mem_rdata` is meaningful only in that cycle. The bench memory model follows this rule: it answers each request after one cycle and drops the acknowledge on the following edge. `req_valid` is raised only while `idle` is high and only for a single cycle. The directory base is changed only between walks.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int ENT_P  = 0;
  localparam int ENT_RW = 1;
  localparam int ENT_US = 2;
  localparam int ENT_A  = 5;
  localparam int ENT_D  = 6;

  typedef enum logic [2:0] {
    W_IDLE,
    W_DIR_RD,
    W_DIR_WB,
    W_TBL_RD,
    W_TBL_WB
  } walk_st_t;
endpackage

// File: rtl/pw_perm.sv
module pw_perm #(
  parameter int ENT_W = 32
) (
  input  logic [ENT_W-1:0] entry,
  input  logic             user,
  input  logic             write,
  output logic             present,
  output logic             allowed
);
  import pw_pkg::*;

  always_comb begin
    present = entry[ENT_P];
    allowed = !user || (entry[ENT_US] && (!write || entry[ENT_RW]));
  end
endmodule

// File: rtl/pw_fault_reg.sv
module pw_fault_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  logic [ADDR_W-1:0] q_d;

  always_comb q_d = load ? d : q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_lin,
  input  logic                    req_write,
  input  logic                    req_user,
  input  logic [ADDR_W-1:0]       dir_base,
  output logic                    idle,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [ADDR_W-1:0]       mem_wdata,
  input  logic [ADDR_W-1:0]       mem_rdata,
  input  logic                    mem_ack,
  output logic                    walk_done,
  output logic                    walk_fault,
  output logic [ADDR_W-1:0]       phys_addr,
  output logic                    fill_valid,
  output logic [ADDR_W-PAGE_BITS-1:0] fill_vpn,
  output logic [ADDR_W-PAGE_BITS-1:0] fill_pfn,
  output logic [ADDR_W-1:0]       fault_addr
);
  import pw_pkg::*;

  localparam int PFN_W = ADDR_W - PAGE_BITS;
  localparam int IDX_W = PAGE_BITS - 2;
  localparam int DIR_LSB = PAGE_BITS + IDX_W;

  walk_st_t          st_q, st_d;
  logic [ADDR_W-1:0] lin_q, lin_d;
  logic              wr_q, wr_d, user_q, user_d;
  logic [PFN_W-1:0]  dbase_q, dbase_d, tbase_q, tbase_d, pfn_q, pfn_d;
  logic [ADDR_W-1:0] wb_q, wb_d;
  logic              done_q, done_d, flt_q, flt_d;
  logic              fin_fault;
  logic              ent_present, ent_allowed;
  logic [ADDR_W-1:0] upd_word;
  logic              need_wb;

  pw_perm #(.ENT_W(ADDR_W)) u_perm (
    .entry   (mem_rdata),
    .user    (user_q),
    .write   (wr_q),
    .present (ent_present),
    .allowed (ent_allowed)
  );

  pw_fault_reg #(.ADDR_W(ADDR_W)) u_fault (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fin_fault),
    .d     (lin_q),
    .q     (fault_addr)
  );

  always_comb begin
    upd_word = mem_rdata;
    upd_word[ENT_A] = 1'b1;
    if (st_q == W_TBL_RD && wr_q) upd_word[ENT_D] = 1'b1;
    need_wb = (upd_word != mem_rdata);
  end

  always_comb begin
    st_d      = st_q;
    lin_d     = lin_q;
    wr_d      = wr_q;
    user_d    = user_q;
    dbase_d   = dbase_q;
    tbase_d   = tbase_q;
    pfn_d     = pfn_q;
    wb_d      = wb_q;
    done_d    = 1'b0;
    flt_d     = 1'b0;
    fin_fault = 1'b0;
    unique case (st_q)
      W_IDLE: if (req_valid) begin
        lin_d   = req_lin;
        wr_d    = req_write;
        user_d  = req_user;
        dbase_d = dir_base[ADDR_W-1:PAGE_BITS];
        st_d    = W_DIR_RD;
      end
      W_DIR_RD: if (mem_ack) begin
        tbase_d = mem_rdata[ADDR_W-1:PAGE_BITS];
        if (!(ent_present && ent_allowed)) begin
          fin_fault = 1'b1;
          done_d = 1'b1; flt_d = 1'b1; st_d = W_IDLE;
        end else if (need_wb) begin
          wb_d = upd_word; st_d = W_DIR_WB;
        end else begin
          st_d = W_TBL_RD;
        end
      end
      W_DIR_WB: if (mem_ack) st_d = W_TBL_RD;
      W_TBL_RD: if (mem_ack) begin
        pfn_d = mem_rdata[ADDR_W-1:PAGE_BITS];
        if (!(ent_present && ent_allowed)) begin
          fin_fault = 1'b1;
          done_d = 1'b1; flt_d = 1'b1; st_d = W_IDLE;
        end else if (need_wb) begin
          wb_d = upd_word; st_d = W_TBL_WB;
        end else begin
          done_d = 1'b1; st_d = W_IDLE;
        end
      end
      W_TBL_WB: if (mem_ack) begin
        done_d = 1'b1; st_d = W_IDLE;
      end
      default: st_d = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= W_IDLE;
      lin_q   <= '0;
      wr_q    <= 1'b0;
      user_q  <= 1'b0;
      dbase_q <= '0;
      tbase_q <= '0;
      pfn_q   <= '0;
      wb_q    <= '0;
      done_q  <= 1'b0;
      flt_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      lin_q   <= lin_d;
      wr_q    <= wr_d;
      user_q  <= user_d;
      dbase_q <= dbase_d;
      tbase_q <= tbase_d;
      pfn_q   <= pfn_d;
      wb_q    <= wb_d;
      done_q  <= done_d;
      flt_q   <= flt_d;
    end
  end

  always_comb begin
    idle      = (st_q == W_IDLE);
    mem_req   = (st_q != W_IDLE);
    mem_we    = (st_q == W_DIR_WB) || (st_q == W_TBL_WB);
    mem_wdata = wb_q;
    if (st_q == W_DIR_RD || st_q == W_DIR_WB)
      mem_addr = {dbase_q, lin_q[ADDR_W-1:DIR_LSB], 2'b00};
    else
      mem_addr = {tbase_q, lin_q[DIR_LSB-1:PAGE_BITS], 2'b00};
    walk_done  = done_q;
    walk_fault = done_q && flt_q;
    fill_valid = done_q && !flt_q;
    fill_vpn   = lin_q[ADDR_W-1:PAGE_BITS];
    fill_pfn   = pfn_q;
    phys_addr  = {pfn_q, lin_q[PAGE_BITS-1:0]};
  end

  // R10: request held steady until acknowledged
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  // R6: every write-back carries the accessed flag
  a_r6_wb_accessed: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[ENT_A]);

  // R9: captured fault address only moves on a faulting completion
  a_r9_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_done && walk_fault) |-> $stable(fault_addr));

  // R4: no fault and fill at once
  a_r4_fault_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    !(walk_fault && fill_valid));
endmodule

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_user = 1'b0;
  logic [31:0] req_lin = '0, dir_base = 32'h0001_0000;
  logic        idle, mem_req, mem_we, walk_done, walk_fault, fill_valid;
  logic [31:0] mem_addr, mem_wdata, phys_addr, fault_addr;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;
  logic [19:0] fill_vpn, fill_pfn;

  int total = 0, bad = 0, wr_cnt = 0, cyc = 0;
  logic [31:0] mem [int unsigned];
  logic [31:0] last_fault = '0;

  always #10 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_lin(req_lin),
    .req_write(req_write), .req_user(req_user), .dir_base(dir_base), .idle(idle),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .walk_done(walk_done),
    .walk_fault(walk_fault), .phys_addr(phys_addr), .fill_valid(fill_valid),
    .fill_vpn(fill_vpn), .fill_pfn(fill_pfn), .fault_addr(fault_addr)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (mem.exists(a >> 2)) return mem[a >> 2];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= rd(mem_addr);
      if (mem_we) begin
        mem[mem_addr >> 2] = mem_wdata;
        wr_cnt++;
      end
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic summary_and_end();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary_and_end();
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] lin;
    logic        wr;
    logic        usr;
    logic        flt;
    logic [31:0] pa;
    logic [31:0] chk_a;
    logic [31:0] chk_w;
    logic [1:0]  nwr;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{32'h0040_0123, 1'b0, 1'b1, 1'b0, 32'h00AB_C123, 32'h0002_0000, 32'h00AB_C027, 2'd2},
    '{32'h0040_0456, 1'b1, 1'b1, 1'b0, 32'h00AB_C456, 32'h0002_0000, 32'h00AB_C067, 2'd1},
    '{32'h0040_1FFF, 1'b1, 1'b1, 1'b0, 32'h00DE_FFFF, 32'h0002_0004, 32'h00DE_F067, 2'd0},
    '{32'h0040_2010, 1'b0, 1'b1, 1'b1, 32'h0,         32'h0001_0004, 32'h0002_0027, 2'd0},
    '{32'h0100_0000, 1'b0, 1'b0, 1'b1, 32'h0,         32'h0001_0010, 32'h0000_0000, 2'd0},
    '{32'h0040_3ABC, 1'b0, 1'b1, 1'b1, 32'h0,         32'h0002_000C, 32'h0012_3003, 2'd0},
    '{32'h0040_3ABC, 1'b1, 1'b0, 1'b0, 32'h0012_3ABC, 32'h0002_000C, 32'h0012_3063, 2'd1},
    '{32'h0080_0044, 1'b1, 1'b1, 1'b1, 32'h0,         32'h0001_0008, 32'h0003_0005, 2'd0},
    '{32'h0080_0044, 1'b0, 1'b1, 1'b0, 32'h0077_7044, 32'h0003_0000, 32'h0077_7027, 2'd2},
    '{32'h00C0_0008, 1'b0, 1'b1, 1'b1, 32'h0,         32'h0001_000C, 32'h0004_0003, 2'd0},
    '{32'h00C0_0008, 1'b1, 1'b0, 1'b0, 32'h0088_8008, 32'h0004_0000, 32'h0088_8067, 2'd2},
    '{32'h0040_4100, 1'b1, 1'b1, 1'b1, 32'h0,         32'h0002_0010, 32'h0045_6005, 2'd0},
    '{32'h0140_0777, 1'b0, 1'b1, 1'b0, 32'h0099_9777, 32'h0005_0000, 32'h0099_9027, 2'd0}
  };

  task automatic walk(input logic [31:0] lin, input logic wr, input logic usr);
    @(negedge clk);
    req_lin = lin; req_write = wr; req_user = usr; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 60 && !walk_done; k++) @(negedge clk);
  endtask

  task automatic check_walk(input string tag, input vec_t v, input int w0);
    chk({tag, " R8 done"}, {31'd0, walk_done}, 32'd1);
    chk({tag, " R4/R5 fault"}, {31'd0, walk_fault}, {31'd0, v.flt});
    chk({tag, " R8 fill"}, {31'd0, fill_valid}, {31'd0, !v.flt});
    if (!v.flt) begin
      chk({tag, " R8 phys"}, phys_addr, v.pa);
      chk({tag, " R8 vpn"}, {12'd0, fill_vpn}, {12'd0, v.lin[31:12]});
      chk({tag, " R3 pfn"}, {12'd0, fill_pfn}, {12'd0, v.pa[31:12]});
    end else begin
      last_fault = v.lin;
    end
    chk({tag, " R9 fault_addr"}, fault_addr, last_fault);
    chk({tag, " R7 writes"}, wr_cnt - w0, {30'd0, v.nwr});
    chk({tag, " R6 entry"}, rd(v.chk_a), v.chk_w);
  endtask

  initial begin
    mem[32'h0001_0004 >> 2] = 32'h0002_0007;
    mem[32'h0001_0008 >> 2] = 32'h0003_0005;
    mem[32'h0001_000C >> 2] = 32'h0004_0003;
    mem[32'h0001_0014 >> 2] = 32'h0005_0027;
    mem[32'h0002_0000 >> 2] = 32'h00AB_C007;
    mem[32'h0002_0004 >> 2] = 32'h00DE_F067;
    mem[32'h0002_000C >> 2] = 32'h0012_3003;
    mem[32'h0002_0010 >> 2] = 32'h0045_6005;
    mem[32'h0003_0000 >> 2] = 32'h0077_7007;
    mem[32'h0004_0000 >> 2] = 32'h0088_8007;
    mem[32'h0005_0000 >> 2] = 32'h0099_9027;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 idle", {31'd0, idle}, 32'd1);
    chk("R1 mem_req", {31'd0, mem_req}, 32'd0);
    chk("R1 done", {31'd0, walk_done}, 32'd0);
    chk("R1 fault_addr", fault_addr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int w0;
      w0 = wr_cnt;
      walk(VECS[i].lin, VECS[i].wr, VECS[i].usr);
      check_walk($sformatf("vec%0d", i), VECS[i], w0);
    end

    // R6: directory entry gets accessed but never dirty, even after a write walk
    chk("R6 dir no dirty", rd(32'h0001_000C), 32'h0004_0023);
    chk("R6 dir accessed", rd(32'h0001_0008), 32'h0003_0025);

    // R2: low bits of the directory base are ignored
    begin
      int w0;
      vec_t v;
      v = '{32'h0140_0321, 1'b0, 1'b1, 1'b0, 32'h0099_9321, 32'h0001_0014, 32'h0005_0027, 2'd0};
      dir_base = 32'h0001_0ABC;
      w0 = wr_cnt;
      walk(v.lin, v.wr, v.usr);
      check_walk("R2 base low bits", v, w0);
      dir_base = 32'h0001_0000;
    end

    // R5: supervisor write through read-only entries is allowed
    begin
      int w0;
      vec_t v;
      v = '{32'h0040_4200, 1'b1, 1'b0, 1'b0, 32'h0045_6200, 32'h0002_0010, 32'h0045_6065, 2'd1};
      w0 = wr_cnt;
      walk(v.lin, v.wr, v.usr);
      check_walk("R5 supervisor ro", v, w0);
    end

    @(negedge clk);
    chk("R10 idle after walks", {31'd0, idle}, 32'd1);
    summary_and_end();
  end
endmodule